// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block gathers the event indications of an I2C controller into one interrupt status word. Ten one-cycle event pulses set sticky status bits. Two level inputs report FIFO threshold conditions and are passed through live. A mask register selects which status bits may raise the single interrupt line.

Software reads the live status, the mask, the masked status and a captured transmit-abort cause through a small register port. Sticky bits are cleared by reading a clear address. There is one clear address per sticky source and one address that clears them all. Because clearing is per source, an event that arrives between a status read and the clear of some other source is kept.

The abort cause word is kept until the abort source's clear address, or the clear-all address, is read. Software must therefore read the cause before it clears the abort.

Top module: `irq_status_top`

Status bit order: 0 receive underflow, 1 receive overflow, 2 transmit overflow, 3 read request, 4 transmit abort, 5 receive done, 6 bus activity, 7 stop seen, 8 start seen, 9 general call. These ten are sticky. Bit 10 is the transmit-level input (`lvlIn[0]`) and bit 11 is the receive-level input (`lvlIn[1]`); both are live.

Register addresses:

| Address | Access | Content |
|---|---|---|
| 0 | read | live status |
| 1 | read/write | mask |
| 2 | read | masked status |
| 3 | read | abort cause |
| 4 | read | clear-all |
| 8+i | read | clear of sticky source i (i = 0..9) |

## Requirements
- R1: After reset the sticky bits, the mask and the abort cause are zero, `irq` is low and `regRdata` is zero.
- R2: A pulse on `evtPulse[i]` sets status bit i, which then stays set until it is cleared by a clear read.
- R3: Status bits 10 and 11 follow `lvlIn[0]` and `lvlIn[1]` directly, and no clear read changes them.
- R4: Address 2 reads the live status ANDed with the mask, and `irq` is high exactly when that masked status is nonzero.
- R5: Writing a mask of zero drives `irq` low and leaves the live status read at address 0 unchanged.
- R6: A read of address 8+i clears only sticky bit i and returns bit i's prior value in bit 0, with all other data bits zero.
- R7: A read of address 4 clears all ten sticky bits and returns in bit 0 the OR of their prior values.
- R8: An event pulse in the same cycle as a clear read of that source leaves the bit set.
- R9: On each pulse of source 4 (transmit abort), `abortCauseIn` is ORed into the abort cause register, which is readable at address 3.
- R10: The abort cause is cleared only by a read of address 12 (the clear of source 4) or address 4; other reads leave it unchanged.
- R11: `regRdata` takes the addressed value on the clock edge where `regRd` is high and holds it otherwise. Reads of unmapped addresses return zero.
- R12: Only a write to address 1 changes the mask (its low 12 bits), and reads of addresses 0 to 3 clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| evtPulse | input | 10 | one-cycle event pulses, one per sticky source |
| lvlIn | input | 2 | FIFO threshold levels (transmit low, receive high) |
| abortCauseIn | input | ABORT_W | abort reason, sampled on a source 4 pulse |
| regAddr | input | ADDR_W | register address |
| regRd | input | 1 | read strobe |
| regWr | input | 1 | write strobe |
| regWdata | input | DATA_W | write data |
| regRdata | output | DATA_W | registered read data |
| irq | output | 1 | interrupt line |

## Verification
A table of event, level and mask patterns is tried. It includes single events, alternating bit patterns, levels alone and everything set. Together these show whether masking and the interrupt line act per bit, and whether level bits are treated differently from sticky ones. Directed sequences then separate per-source clearing from clear-all, and they show that an event coinciding with its own clear survives. Abort cause patterns check that the cause accumulates, that unrelated clears keep it, and that the two proper clears erase it.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int EV_COUNT  = 10;
  localparam int LVL_COUNT = 2;
  localparam int SRC_COUNT = EV_COUNT + LVL_COUNT;
  localparam int EV_ABORT  = 4;

  localparam int A_RAW     = 0;
  localparam int A_MASK    = 1;
  localparam int A_MSKD    = 2;
  localparam int A_ABORT   = 3;
  localparam int A_CLRALL  = 4;
  localparam int A_CLRBASE = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RAW, SEL_MASK, SEL_MSKD, SEL_ABORT, SEL_CLRONE, SEL_CLRALL
  } rdsel_e;

  typedef struct packed {
    logic                rdEn;
    rdsel_e              rdSel;
    logic                clrAll;
    logic [EV_COUNT-1:0] clrSrc;
    logic                maskWr;
  } strobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output strobe_t           strb
);
  logic [EV_COUNT-1:0] clrHit;

  for (genvar i = 0; i < EV_COUNT; i++) begin : g_hit
    assign clrHit[i] = (regAddr == ADDR_W'(A_CLRBASE + i));
  end

  always_comb begin
    strb        = '0;
    strb.rdEn   = regRd;
    strb.rdSel  = SEL_NONE;
    strb.maskWr = regWr && (regAddr == ADDR_W'(A_MASK));
    if (regRd) begin
      if (regAddr == ADDR_W'(A_RAW))         strb.rdSel = SEL_RAW;
      else if (regAddr == ADDR_W'(A_MASK))   strb.rdSel = SEL_MASK;
      else if (regAddr == ADDR_W'(A_MSKD))   strb.rdSel = SEL_MSKD;
      else if (regAddr == ADDR_W'(A_ABORT))  strb.rdSel = SEL_ABORT;
      else if (regAddr == ADDR_W'(A_CLRALL)) begin
        strb.rdSel  = SEL_CLRALL;
        strb.clrAll = 1'b1;
      end else if (|clrHit) begin
        strb.rdSel  = SEL_CLRONE;
        strb.clrSrc = clrHit;
      end
    end
  end

  // R6: at most one per-source clear per cycle
  assert_one_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.clrSrc));
  // R12: no clear strobe without a read
  assert_no_clear_on_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |-> (strb.clrSrc == '0 && !strb.clrAll));
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ABORT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [EV_COUNT-1:0]  evtPulse,
  input  logic [LVL_COUNT-1:0] lvlIn,
  input  logic [ABORT_W-1:0]   abortCauseIn,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irq
);
  logic [EV_COUNT-1:0]  stickyQ;
  logic [SRC_COUNT-1:0] maskQ;
  logic [ABORT_W-1:0]   abortQ;
  logic [SRC_COUNT-1:0] rawStatus;
  logic [SRC_COUNT-1:0] maskedStatus;
  logic [EV_COUNT-1:0]  clrVec;
  logic                 abortClr;
  logic                 unusedWdata;

  assign unusedWdata  = ^regWdata[DATA_W-1:SRC_COUNT];
  assign rawStatus    = {lvlIn, stickyQ};
  assign maskedStatus = rawStatus & maskQ;
  assign irq          = |maskedStatus;
  assign abortClr     = clrVec[EV_ABORT];

  for (genvar i = 0; i < EV_COUNT; i++) begin : g_sticky
    assign clrVec[i] = strb.clrAll | strb.clrSrc[i];
    always_ff @(posedge clk) begin
      if (!rstN) stickyQ[i] <= 1'b0;
      else       stickyQ[i] <= (stickyQ[i] & ~clrVec[i]) | evtPulse[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '0;
    else if (strb.maskWr) maskQ <= regWdata[SRC_COUNT-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) abortQ <= '0;
    else if (evtPulse[EV_ABORT]) abortQ <= (abortClr ? '0 : abortQ) | abortCauseIn;
    else if (abortClr) abortQ <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else if (strb.rdEn) begin
      unique case (strb.rdSel)
        SEL_RAW:    regRdata <= DATA_W'(rawStatus);
        SEL_MASK:   regRdata <= DATA_W'(maskQ);
        SEL_MSKD:   regRdata <= DATA_W'(maskedStatus);
        SEL_ABORT:  regRdata <= DATA_W'(abortQ);
        SEL_CLRONE: regRdata <= DATA_W'(|(stickyQ & strb.clrSrc));
        SEL_CLRALL: regRdata <= DATA_W'(|stickyQ);
        default:    regRdata <= '0;
      endcase
    end
  end

  // R2/R8: every pulsed event is visible next cycle, clear or not
  assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((stickyQ & $past(evtPulse)) == $past(evtPulse)));
  // R6/R7: a cleared bit with no coinciding event reads zero afterwards
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrVec & ~evtPulse)) |=> ((stickyQ & $past(clrVec & ~evtPulse)) == '0));
  // R2: without events or clears the sticky bits hold
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse == '0 && clrVec == '0) |=> $stable(stickyQ));
  // R12: mask takes the written value
  assert_mask_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> (maskQ == $past(regWdata[SRC_COUNT-1:0])));
  // R10: abort clear without new abort empties the cause
  assert_abort_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (abortClr && !evtPulse[EV_ABORT]) |=> (abortQ == '0));
endmodule

// File: rtl/irq_status_top.sv
module irq_status_top
  import irq_status_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int ABORT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EV_COUNT-1:0]  evtPulse,
  input  logic [LVL_COUNT-1:0] lvlIn,
  input  logic [ABORT_W-1:0]   abortCauseIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irq
);
  strobe_t strb;

  irq_status_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd),
    .regWr(regWr), .strb(strb)
  );

  irq_status_dp #(.DATA_W(DATA_W), .ABORT_W(ABORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtPulse(evtPulse),
    .lvlIn(lvlIn), .abortCauseIn(abortCauseIn), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );
endmodule

// File: tb/tb_irq_status_top.sv
module tb_irq_status_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int ABORT_W = 16;

  // {evt[9:0], lvl[1:0], mask[11:0]}
  localparam logic [23:0] VEC [6] = '{
    {10'h001, 2'b00, 12'h001},
    {10'h200, 2'b00, 12'h000},
    {10'h000, 2'b01, 12'h400},
    {10'h0AA, 2'b10, 12'h802},
    {10'h155, 2'b00, 12'h0AA},
    {10'h3FF, 2'b11, 12'hFFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] evtPulse = '0;
  logic [1:0] lvlIn = '0;
  logic [ABORT_W-1:0] abortCauseIn = '0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regRd = 1'b0;
  logic regWr = 1'b0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ABORT_W(ABORT_W)) dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .lvlIn(lvlIn),
    .abortCauseIn(abortCauseIn), .regAddr(regAddr), .regRd(regRd),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] d);
    @(negedge clk); regAddr = ADDR_W'(a); regRd = 1'b1;
    @(negedge clk); regRd = 1'b0; d = regRdata;
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk); regAddr = ADDR_W'(a); regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] e, input logic [ABORT_W-1:0] cause);
    @(negedge clk); evtPulse = e; abortCauseIn = cause;
    @(negedge clk); evtPulse = '0; abortCauseIn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 rdata", regRdata, 0);
    check("R1 irq", irq, 0);
    rd(0, d); check("R1 raw", d, 0);
    rd(1, d); check("R1 mask", d, 0);
    rd(3, d); check("R1 abort", d, 0);

    // table: R2 R3 R4
    for (int k = 0; k < 6; k++) begin
      logic [9:0] e; logic [1:0] l; logic [11:0] m; logic [11:0] expRaw;
      {e, l, m} = VEC[k];
      expRaw = {l, e};
      rd(4, d);
      @(negedge clk); lvlIn = l;
      pulse(e, '0);
      wr(1, 16'(m));
      rd(0, d);  check($sformatf("R2 raw vec%0d", k), d, 32'(expRaw));
      rd(2, d);  check($sformatf("R4 masked vec%0d", k), d, 32'(expRaw & m));
      check($sformatf("R4 irq vec%0d", k), irq, 32'(|(expRaw & m)));
    end
    @(negedge clk); lvlIn = '0;
    wr(1, 0);
    rd(4, d);

    // R6 per-source clear
    pulse(10'h088, '0);
    rd(8 + 3, d); check("R6 clr3 ret", d, 1);
    rd(0, d);     check("R6 raw after clr3", d, 16'h080);
    rd(8 + 3, d); check("R6 clr3 again", d, 0);
    rd(8 + 7, d); check("R6 clr7 ret", d, 1);
    rd(0, d);     check("R6 raw empty", d, 0);

    // R11 R12 non-clearing reads, ignored writes, unmapped
    pulse(10'h020, '0);
    rd(0, d); rd(0, d); check("R12 raw not cleared", d, 16'h020);
    held = d;
    @(negedge clk); check("R11 rdata holds", regRdata, 32'(held));
    wr(0, 16'hFFFF); rd(1, d); check("R12 mask unchanged", d, 0);
    rd(5, d);  check("R11 unmapped 5", d, 0);
    rd(31, d); check("R11 unmapped 31", d, 0);
    rd(0, d);  check("R12 raw after unmapped", d, 16'h020);

    // R7 clear-all, R3 levels survive
    @(negedge clk); lvlIn = 2'b11;
    pulse(10'h3FF, '0);
    rd(4, d); check("R7 clrall ret", d, 1);
    rd(0, d); check("R3 levels stay", d, 16'hC00);
    rd(4, d); check("R7 clrall empty", d, 0);
    @(negedge clk); lvlIn = 2'b00;

    // R8 event during clear
    pulse(10'h004, '0);
    @(negedge clk); evtPulse = 10'h004; regAddr = ADDR_W'(8 + 2); regRd = 1'b1;
    @(negedge clk); evtPulse = '0; regRd = 1'b0;
    check("R8 clr ret", regRdata, 1);
    rd(0, d); check("R8 bit kept", d, 16'h004);
    @(negedge clk); evtPulse = 10'h200; regAddr = ADDR_W'(4); regRd = 1'b1;
    @(negedge clk); evtPulse = '0; regRd = 1'b0;
    rd(0, d); check("R8 clrall keeps new", d, 16'h200);
    rd(4, d);

    // R9 R10 abort cause
    pulse(10'h010, 16'h0013);
    pulse(10'h010, 16'h0100);
    rd(3, d); check("R9 cause accum", d, 16'h0113);
    rd(0, d); check("R9 raw abort", d, 16'h010);
    rd(8 + 2, d); rd(3, d); check("R10 cause kept", d, 16'h0113);
    rd(12, d); check("R10 clr ret", d, 1);
    rd(3, d);  check("R10 cause cleared", d, 0);
    pulse(10'h010, 16'h0005);
    rd(4, d); rd(3, d); check("R10 clrall cause", d, 0);

    // R5 mask zero
    wr(1, 16'h0FFF);
    pulse(10'h001, '0);
    check("R5 irq on", irq, 1);
    wr(1, 0);
    check("R5 irq off", irq, 0);
    rd(0, d); check("R5 raw unchanged", d, 16'h001);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule